// File: doc/BRIEF.md
# Secondary-Device Diagnostic Handshake Controller

This block sits in the secondary device of a two-device storage bus. It sequences the shared, active-low, open-collector "passed diagnostics" line that the primary device watches. It also produces the device's BSY and DRDY status bits and a command-accept enable. A sequence starts on any of three reset kinds: power-on, software, or hardware. It also starts when a valid execute-diagnostic command arrives while the device is accepting commands.

In every sequence the block releases the pass line at once and raises BSY. It then pulses a start request to the internal self-test engine and waits for the engine's done/pass report. On a pass, it drops BSY for one cycle with the line still released. It then drives the line low. DRDY and command acceptance follow only after a settle period.

A failed self-test drops BSY and sets DRDY with the line left released. A self-test that does not report before its deadline leaves a sticky timeout flag and the line released. All deadlines count ticks from an internal prescaler, so they can be scaled down for simulation.

Top module: `diag_handshake_ctrl`

## Requirements
- R1: While `rst_n` (power-on reset) is low, and in the first cycle after it rises, `pass_oe`=0, `bsy`=1, `drdy`=0, `cmd_accept`=0, `timeout`=0 and `st_start`=1.
- R2: A `soft_rst` or `hw_rst` pulse in any state gives `pass_oe`=0, `bsy`=1, `drdy`=0 and `cmd_accept`=0 in the next cycle, and restarts the reset deadline from zero.
- R3: While `bsy`=1, `st_done`=1 with `st_pass`=1 makes `bsy`=0 in the next cycle with `pass_oe` still 0, and `pass_oe`=1 one cycle later.
- R4: `pass_oe` (1 = pull the line low, 0 = release it) never equals 1 while `bsy`=1, and it rises only when `bsy` has been 0 for at least one cycle before.
- R5: After `pass_oe` rises, `drdy` and `cmd_accept` stay 0 for READY_TICKS prescaler ticks and then both become 1.
- R6: `diag_cmd`=1 while `cmd_accept`=1 gives `pass_oe`=0, `bsy`=1, `drdy`=0, `cmd_accept`=0 and `st_start`=1 in the next cycle.
- R7: `diag_cmd` while `cmd_accept`=0 has no effect on any output.
- R8: If no `st_done` arrives within RST_TICKS ticks of a reset, `timeout`=1, `bsy`=0 and `pass_oe`=0 follow, and they hold until the next reset. A `st_done` in the deadline cycle wins over the timeout.
- R9: If no `st_done` arrives within DIAG_TICKS ticks of an accepted diagnostic command, the same timeout state is entered.
- R10: While `bsy`=1, `st_done`=1 with `st_pass`=0 gives `bsy`=0, `pass_oe`=0, `drdy`=1 and `cmd_accept`=1 in the next cycle.
- R11: `st_start` is a single-cycle pulse, raised only in the first cycle of a busy phase.
- R12: The prescaler issues one tick every TICK_DIV clocks counted from power-on reset, and software or hardware resets do not re-phase it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset pulse |
| hw_rst | input | 1 | Hardware reset pulse from the bus |
| diag_cmd | input | 1 | Pulse for a valid execute-diagnostic command |
| st_done | input | 1 | Self-test engine reports completion |
| st_pass | input | 1 | Self-test result, valid with st_done |
| pass_oe | output | 1 | 1 = pull pass line low (asserted), 0 = release to pull-up |
| bsy | output | 1 | BSY status bit |
| drdy | output | 1 | DRDY status bit |
| cmd_accept | output | 1 | Commands may be accepted |
| timeout | output | 1 | Self-test deadline expired (sticky until reset) |
| st_start | output | 1 | One-cycle request to start the self-test |

## Verification
The bound checker checks the following on every cycle:
- the release and BSY that follow a software or hardware reset;
- the ordering of BSY falling before the pass line is pulled;
- the gap before command acceptance while the line is pulled;
- the diagnostic-command entry and the pass and fail exits from a busy phase;
- the stickiness of the timeout flag and the single-cycle start pulse.

Only the bench's scenarios can show the exact tick-counted deadlines for reset, diagnostic and settle. The same holds for a command being ignored while busy or timed out, and for a reset arriving mid-settle or mid-diagnostic. A behavioural model, stepped every clock, covers these.

// File: rtl/diag_pkg.sv
package diag_pkg;

    typedef enum logic [2:0] {
        PH_RST_BUSY  = 3'd0,
        PH_DIAG_BUSY = 3'd1,
        PH_DROP_BSY  = 3'd2,
        PH_SETTLE    = 3'd3,
        PH_READY     = 3'd4,
        PH_FAILED    = 3'd5,
        PH_TIMEOUT   = 3'd6
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   start;
    } ctrl_s;

endpackage

// File: rtl/diag_tick_gen.sv
module diag_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            logic [W-1:0] pre_d, pre_q;

            always_comb begin
                if (pre_q == W'(DIV - 1)) pre_d = '0;
                else                      pre_d = pre_q + W'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign tick = (pre_q == W'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/diag_timer.sv
module diag_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = tick && (cnt_q == limit - W'(1));

endmodule

// File: rtl/diag_handshake_ctrl.sv
module diag_handshake_ctrl
    import diag_pkg::*;
#(
    parameter int TICK_DIV    = 100000,
    parameter int RST_TICKS   = 30000,
    parameter int DIAG_TICKS  = 5000,
    parameter int READY_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic hw_rst,
    input  logic diag_cmd,
    input  logic st_done,
    input  logic st_pass,
    output logic pass_oe,
    output logic bsy,
    output logic drdy,
    output logic cmd_accept,
    output logic timeout,
    output logic st_start
);

    localparam int MAX_A = (RST_TICKS > DIAG_TICKS) ? RST_TICKS : DIAG_TICKS;
    localparam int MAX_T = (MAX_A > READY_TICKS) ? MAX_A : READY_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);

    ctrl_s            cur_q, nxt_d;
    logic             tick, hit, clr;
    logic [CNT_W-1:0] limit;
    logic             restart;

    diag_tick_gen #(.DIV(TICK_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    diag_timer #(.W(CNT_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (tick),
        .limit (limit),
        .hit   (hit)
    );

    assign restart = soft_rst | hw_rst;

    always_comb begin
        case (cur_q.phase)
            PH_RST_BUSY:  limit = CNT_W'(RST_TICKS);
            PH_DIAG_BUSY: limit = CNT_W'(DIAG_TICKS);
            default:      limit = CNT_W'(READY_TICKS);
        endcase
    end

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.start = 1'b0;
        if (restart) begin
            nxt_d.phase = PH_RST_BUSY;
            nxt_d.start = 1'b1;
        end else begin
            case (cur_q.phase)
                PH_RST_BUSY, PH_DIAG_BUSY: begin
                    if (st_done) nxt_d.phase = st_pass ? PH_DROP_BSY : PH_FAILED;
                    else if (hit) nxt_d.phase = PH_TIMEOUT;
                end
                PH_DROP_BSY: nxt_d.phase = PH_SETTLE;
                PH_SETTLE: begin
                    if (hit) nxt_d.phase = PH_READY;
                end
                PH_READY, PH_FAILED: begin
                    if (diag_cmd) begin
                        nxt_d.phase = PH_DIAG_BUSY;
                        nxt_d.start = 1'b1;
                    end
                end
                default: nxt_d.phase = cur_q.phase;
            endcase
        end
        clr = restart || (nxt_d.phase != cur_q.phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.phase <= PH_RST_BUSY;
            cur_q.start <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bsy        = (cur_q.phase == PH_RST_BUSY) || (cur_q.phase == PH_DIAG_BUSY);
    assign pass_oe    = (cur_q.phase == PH_SETTLE) || (cur_q.phase == PH_READY);
    assign drdy       = (cur_q.phase == PH_READY) || (cur_q.phase == PH_FAILED);
    assign cmd_accept = drdy;
    assign timeout    = (cur_q.phase == PH_TIMEOUT);
    assign st_start   = cur_q.start;

endmodule

// File: rtl/diag_handshake_chk.sv
module diag_handshake_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic hw_rst,
    input logic diag_cmd,
    input logic st_done,
    input logic st_pass,
    input logic pass_oe,
    input logic bsy,
    input logic drdy,
    input logic cmd_accept,
    input logic timeout,
    input logic st_start
);

    logic quiet;
    assign quiet = !soft_rst && !hw_rst;

    a_r2_restart_release: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst || hw_rst) |=> (bsy && !pass_oe && !drdy && !cmd_accept));

    a_r3_pass_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy && st_done && st_pass && quiet) |=> (!bsy && !pass_oe));

    a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_oe && bsy));

    a_r4_bsy_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_oe) |-> (!bsy && $past(!bsy)));

    a_r5_no_accept_early: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_oe && !drdy) |-> !cmd_accept);

    a_r6_diag_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_cmd && cmd_accept && quiet) |=> (bsy && !pass_oe && !cmd_accept && st_start));

    a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && quiet) |=> (timeout && !pass_oe && !bsy));

    a_r10_fail_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy && st_done && !st_pass && quiet) |=> (!bsy && !pass_oe && drdy && cmd_accept));

    a_r11_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        (st_start && quiet) |=> !st_start);

endmodule

bind diag_handshake_ctrl diag_handshake_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .hw_rst     (hw_rst),
    .diag_cmd   (diag_cmd),
    .st_done    (st_done),
    .st_pass    (st_pass),
    .pass_oe    (pass_oe),
    .bsy        (bsy),
    .drdy       (drdy),
    .cmd_accept (cmd_accept),
    .timeout    (timeout),
    .st_start   (st_start)
);

// File: tb/test_diag_handshake_ctrl.sv
`timescale 1ns/1ps
module test_diag_handshake_ctrl;

    localparam int DIV  = 4;
    localparam int RSTT = 12;
    localparam int DIAT = 6;
    localparam int RDYT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, hw_rst = 1'b0, diag_cmd = 1'b0, st_done = 1'b0, st_pass = 1'b0;
    logic pass_oe, bsy, drdy, cmd_accept, timeout, st_start;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    diag_handshake_ctrl #(
        .TICK_DIV(DIV), .RST_TICKS(RSTT), .DIAG_TICKS(DIAT), .READY_TICKS(RDYT)
    ) i_diag_handshake_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .hw_rst(hw_rst),
        .diag_cmd(diag_cmd), .st_done(st_done), .st_pass(st_pass),
        .pass_oe(pass_oe), .bsy(bsy), .drdy(drdy), .cmd_accept(cmd_accept),
        .timeout(timeout), .st_start(st_start)
    );

    // behavioural reference: 0 reset-busy, 1 diag-busy, 2 bsy dropped, 3 settle,
    // 4 ready, 5 failed, 6 timed out
    int m_st = 0, m_ticks = 0, m_pre = 0;
    bit m_start = 1'b1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ticks = 0; m_pre = 0; m_start = 1'b1;
        end else begin
            bit tk;
            int lim, nst;
            bit nstart;
            tk  = (m_pre == DIV - 1);
            lim = (m_st == 0) ? RSTT : (m_st == 1) ? DIAT : RDYT;
            nst = m_st;
            nstart = 1'b0;
            if (soft_rst || hw_rst) begin
                nst = 0; nstart = 1'b1;
            end else if (m_st == 0 || m_st == 1) begin
                if (st_done) nst = st_pass ? 2 : 5;
                else if (tk && m_ticks == lim - 1) nst = 6;
            end else if (m_st == 2) begin
                nst = 3;
            end else if (m_st == 3) begin
                if (tk && m_ticks == lim - 1) nst = 4;
            end else if ((m_st == 4 || m_st == 5) && diag_cmd) begin
                nst = 1; nstart = 1'b1;
            end
            if (soft_rst || hw_rst || nst != m_st) m_ticks = 0;
            else if (tk) m_ticks = m_ticks + 1;
            m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
            m_st = nst;
            m_start = nstart;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R4",  "model pass_oe",    pass_oe,    (m_st == 3 || m_st == 4));
            chk("R3",  "model bsy",        bsy,        (m_st == 0 || m_st == 1));
            chk("R5",  "model drdy",       drdy,       (m_st == 4 || m_st == 5));
            chk("R5",  "model cmd_accept", cmd_accept, (m_st == 4 || m_st == 5));
            chk("R8",  "model timeout",    timeout,    (m_st == 6));
            chk("R11", "model st_start",   st_start,   m_start);
        end
    end

    task automatic finish_tb();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_tb();
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic done_pulse(bit ok);
        @(negedge clk); st_done = 1'b1; st_pass = ok;
        @(negedge clk); st_done = 1'b0; st_pass = 1'b0;
    endtask

    task automatic outs(string req, int p, int b, int d, int a, int t);
        chk(req, "pass_oe", pass_oe, p);
        chk(req, "bsy", bsy, b);
        chk(req, "drdy", drdy, d);
        chk(req, "cmd_accept", cmd_accept, a);
        chk(req, "timeout", timeout, t);
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!drdy && n < 100) begin
            if (pass_oe) chk("R5", "accept while settling", cmd_accept, 0);
            cyc(1); n++;
        end
        chk("R5", "drdy after settle", drdy, 1);
        chk("R5", "cmd_accept after settle", cmd_accept, 1);
        chk("R5", "settle length within window", (n >= (RDYT - 1) * DIV && n <= RDYT * DIV + 2), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        outs("R1", 0, 1, 0, 0, 0);
        chk("R1", "st_start at reset", st_start, 1);
        rst_n = 1'b1;
        cyc(1);
        chk("R11", "start pulse ends", st_start, 0);
        // R12: prescaler period shows in reset deadline; checked by the model
        cyc(2);
        pulse(diag_cmd);
        chk("R7", "diag ignored while busy (bsy)", bsy, 1);
        chk("R7", "diag ignored while busy (st_start)", st_start, 0);
        done_pulse(1'b1);
        outs("R3", 0, 0, 0, 0, 0);
        cyc(1);
        chk("R3", "pass pulled after bsy drop", pass_oe, 1);
        chk("R4", "bsy clear with pass", bsy, 0);
        pulse(diag_cmd);
        chk("R7", "diag ignored while settling", cmd_accept, 0);
        wait_ready();
        pulse(diag_cmd);
        outs("R6", 0, 1, 0, 0, 0);
        chk("R6", "st_start on diag", st_start, 1);
        done_pulse(1'b1);
        cyc(1);
        wait_ready();
        pulse(diag_cmd);
        cyc(DIAT * DIV + 4);
        outs("R9", 0, 0, 0, 0, 1);
        pulse(diag_cmd);
        outs("R7", 0, 0, 0, 0, 1);
        pulse(hw_rst);
        outs("R2", 0, 1, 0, 0, 0);
        chk("R2", "st_start after hw reset", st_start, 1);
        cyc(3);
        done_pulse(1'b0);
        outs("R10", 0, 0, 1, 1, 0);
        pulse(diag_cmd);
        outs("R6", 0, 1, 0, 0, 0);
        cyc(DIV * 2);
        pulse(soft_rst);
        outs("R2", 0, 1, 0, 0, 0);
        cyc(RSTT * DIV - 6);
        chk("R8", "no timeout before deadline", timeout, 0);
        cyc(12);
        outs("R8", 0, 0, 0, 0, 1);
        cyc(5);
        chk("R8", "timeout sticky", timeout, 1);
        pulse(soft_rst);
        done_pulse(1'b1);
        cyc(2);
        chk("R3", "pass pulled before mid-settle reset", pass_oe, 1);
        pulse(hw_rst);
        outs("R2", 0, 1, 0, 0, 0);
        cyc(20);
        finish_tb();
    end

endmodule